// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces, beat by beat, the column addresses of a single read or write burst inside a device-side SDRAM model. A start strobe loads a starting column together with the burst length code and the burst order bit. From the next cycle the block presents one column per clock with a valid flag, and it raises a last-beat flag on the closing beat of a fixed-length burst. Data storage, row and bank selection and command decoding are handled elsewhere. This block only says which column is being accessed on each beat.

Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned group of columns. They use either a counting order or an XOR order. A full-page burst walks every column of the row in turn, wraps past the top column to zero, and continues until it is stopped or replaced by a new start. A low clock enable freezes the whole sequencer so that the burst position is held. Reset is asserted asynchronously and released on a clock edge through a two-stage synchronizer.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is active and after it is released with no start, valid and last are 0 and col is 0.
- R2: A start strobe sampled with cke high makes valid 1 and col equal to the sampled start_col on the next cycle.
- R3: len_code is decoded at start as 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats and 7 = full page. The codes 4, 5 and 6 give a 1-beat burst.
- R4: With ilv = 0 and a fixed length BL > 1, the low log2(BL) column bits of beat n equal (start_col + n) mod BL. The higher bits keep the start value.
- R5: With ilv = 1 and a fixed length BL > 1, the low log2(BL) column bits of beat n equal start_col XOR n. The higher bits keep the start value.
- R6: last is 1 only on beat BL-1 of a fixed-length burst. On the cycle after that beat, valid is 0 unless a new start was sampled.
- R7: A full-page burst presents start_col + n mod 256 on beat n, so it wraps from 0xFF to 0x00. It ignores ilv, never raises last, and stays valid until it is ended.
- R8: A stop strobe sampled with cke high and no start ends the burst, so valid is 0 on the next cycle.
- R9: A start strobe overrides a burst in progress and any stop strobe on the same cycle. The next cycle shows beat 0 of the new burst.
- R10: While cke is sampled low, start and stop are ignored and col, valid and last hold their values on the following cycles.
- R11: len_code and ilv only take effect at a start. Changing them during a burst does not alter its columns or its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable; low freezes the sequencer |
| start | input | 1 | Begin a new burst at start_col |
| start_col | input | COL_W | Starting column of the burst |
| len_code | input | 3 | Burst length code, sampled at start |
| ilv | input | 1 | Burst order at start: 0 counting, 1 XOR |
| stop | input | 1 | Terminate the current burst |
| col | output | COL_W | Column of the current beat |
| valid | output | 1 | A burst beat is being presented |
| last | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The bench builds the block with the default COL_W of 8, which gives a 256-column row. With that width, a full-page burst that starts at 0xFE crosses the top column within two beats, and a complete lap of the row with wrap fits in a few hundred cycles. The vector table covers every length code, including a reserved one, in both orders, with starting columns chosen so that each counting order wraps inside its aligned group. Directed runs then cover freezes with start and stop held at the pins, overriding starts, and stops on both burst kinds.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  // Burst length codes sampled at start
  localparam logic [2:0] LEN_ONE   = 3'd0;
  localparam logic [2:0] LEN_TWO   = 3'd1;
  localparam logic [2:0] LEN_FOUR  = 3'd2;
  localparam logic [2:0] LEN_EIGHT = 3'd3;
  localparam logic [2:0] LEN_PAGE  = 3'd7;
  // Largest fixed burst, as the width of its offset field
  localparam int unsigned MAX_FIX_BITS = 3;
endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bcs_len_dec.sv
module bcs_len_dec
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [2:0]       code,
  output logic             full,
  output logic [COL_W-1:0] mask
);
  localparam int unsigned FIX_W = MAX_FIX_BITS;

  logic [FIX_W-1:0] small_mask;

  always_comb begin
    full       = 1'b0;
    small_mask = '0;
    unique case (code)
      LEN_TWO:   small_mask = FIX_W'(1);
      LEN_FOUR:  small_mask = FIX_W'(3);
      LEN_EIGHT: small_mask = FIX_W'(7);
      LEN_PAGE:  full       = 1'b1;
      default:   small_mask = '0;
    endcase
  end

  assign mask = COL_W'(small_mask);
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] dec_mask,
  input  logic             dec_full,
  input  logic             ilv_in,
  output logic             active_q,
  output logic [COL_W-1:0] beat_q,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] mask_q,
  output logic             full_q,
  output logic             ilv_q,
  output logic             last
);
  logic             active_d;
  logic [COL_W-1:0] beat_d;
  logic [COL_W-1:0] base_d;
  logic [COL_W-1:0] mask_d;
  logic             full_d;
  logic             ilv_d;

  assign last = active_q && !full_q && (beat_q == mask_q);

  // Next state
  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    base_d   = base_q;
    mask_d   = mask_q;
    full_d   = full_q;
    ilv_d    = ilv_q;
    if (start) begin
      active_d = 1'b1;
      beat_d   = '0;
      base_d   = start_col;
      mask_d   = dec_mask;
      full_d   = dec_full;
      ilv_d    = ilv_in;
    end else if (active_q) begin
      if (stop || last) active_d = 1'b0;
      else              beat_d   = beat_q + COL_W'(1);
    end
  end

  // State registers, enabled by cke
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
    end else if (cke) begin
      active_q <= active_d;
      beat_q   <= beat_d;
      base_q   <= base_d;
      mask_q   <= mask_d;
      full_q   <= full_d;
      ilv_q    <= ilv_d;
    end
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             full,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;

  assign sum = base + beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    logic wrap_bit;
    assign wrap_bit = ilv ? (base[i] ^ beat[i]) : sum[i];
    assign col[i]   = full    ? sum[i]   :
                      mask[i] ? wrap_bit : base[i];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             ilv,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic             last
);
  logic             rst_sync_n;
  logic             dec_full;
  logic [COL_W-1:0] dec_mask;
  logic             active_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  logic             ilv_q;

  bcs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bcs_len_dec #(.COL_W(COL_W)) u_dec (
    .code (len_code),
    .full (dec_full),
    .mask (dec_mask)
  );

  bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cke       (cke),
    .start     (start),
    .stop      (stop),
    .start_col (start_col),
    .dec_mask  (dec_mask),
    .dec_full  (dec_full),
    .ilv_in    (ilv),
    .active_q  (active_q),
    .beat_q    (beat_q),
    .base_q    (base_q),
    .mask_q    (mask_q),
    .full_q    (full_q),
    .ilv_q     (ilv_q),
    .last      (last)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base (base_q),
    .beat (beat_q),
    .mask (mask_q),
    .full (full_q),
    .ilv  (ilv_q),
    .col  (col)
  );

  assign valid = active_q;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             start,
  input logic             stop,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col,
  input logic             valid,
  input logic             last,
  input logic             full_q
);
  assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);

  assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && last && !start) |=> !valid);

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && start) |=> (valid && col == $past(start_col)));

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && stop && !start) |=> !valid);

  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(col) && $stable(valid) && $stable(last)));

  assert_page_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && valid && full_q && !start && !stop)
      |=> (valid && col == COL_W'($past(col) + 1'b1)));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cke       (cke),
  .start     (start),
  .stop      (stop),
  .start_col (start_col),
  .col       (col),
  .valid     (valid),
  .last      (last),
  .full_q    (full_q)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cke;
  logic       start;
  logic [7:0] start_col;
  logic [2:0] len_code;
  logic       ilv;
  logic       stop;
  logic [7:0] col;
  logic       valid;
  logic       last;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  burst_col_seq u_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .cke(cke), .start(start), .start_col(start_col),
    .len_code(len_code), .ilv(ilv), .stop(stop),
    .col(col), .valid(valid), .last(last)
  );

  // {len_code, ilv, start_col, expected column of the final beat}
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {3'd3, 1'b0, 8'h5D, 8'h5C},
    {3'd3, 1'b1, 8'h5D, 8'h5A},
    {3'd3, 1'b1, 8'h03, 8'h04},
    {3'd2, 1'b0, 8'h0E, 8'h0D},
    {3'd2, 1'b1, 8'h0F, 8'h0C},
    {3'd1, 1'b0, 8'hFF, 8'hFE},
    {3'd1, 1'b1, 8'h80, 8'h81},
    {3'd0, 1'b0, 8'h33, 8'h33},
    {3'd4, 1'b1, 8'h44, 8'h44},
    {3'd6, 1'b0, 8'h71, 8'h71}
  };

  function automatic int ref_len(input logic [2:0] code);
    case (code)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] ref_col(input logic [7:0] s, input logic [2:0] code,
                                         input logic il, input int n);
    logic [7:0] m;
    logic [7:0] nb;
    nb = n[7:0];
    if (code == 3'd7) return s + nb;
    m = 8'(ref_len(code) - 1);
    if (il) return s ^ (nb & m);
    return (s & ~m) | ((s + nb) & m);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    start = 1'b0; stop = 1'b0; cke = 1'b1;
  endtask

  task automatic begin_burst(input logic [2:0] code, input logic il, input logic [7:0] s);
    @(negedge clk);
    start = 1'b1; start_col = s; len_code = code; ilv = il;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_col = '0; len_code = '0; ilv = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid in reset", {7'd0, valid}, 8'd0);
    check("R1 last in reset", {7'd0, last}, 8'd0);
    check("R1 col in reset", col, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid after release", {7'd0, valid}, 8'd0);

    // Vector table: R2 R3 R4 R5 R6 R11
    for (int v = 0; v < NV; v++) begin
      logic [2:0] code;
      logic       il;
      logic [7:0] s;
      int         bl;
      code = VEC[v][19:17]; il = VEC[v][16]; s = VEC[v][15:8];
      bl = ref_len(code);
      begin_burst(code, il, s);
      len_code = 3'd7; ilv = ~il;  // R11: changes after start have no effect
      check("R2 first column", col, s);
      for (int n = 0; n < bl; n++) begin
        check(il ? "R5 interleaved column" : "R4 sequential column", col, ref_col(s, code, il, n));
        check("R3 valid during burst", {7'd0, valid}, 8'd1);
        check("R6 last flag", {7'd0, last}, {7'd0, (n == bl - 1)});
        if (n == bl - 1) check("R11 final column", col, VEC[v][7:0]);
        else @(negedge clk);
      end
      @(negedge clk);
      check("R6 valid low after last", {7'd0, valid}, 8'd0);
    end

    // R7: full page wraps, ignores ilv, no last; R8: stop ends it
    begin_burst(3'd7, 1'b1, 8'hFE);
    for (int n = 0; n < 260; n++) begin
      check("R7 page column", col, 8'hFE + 8'(n));
      check("R7 page no last", {7'd0, last}, 8'd0);
      check("R7 page valid", {7'd0, valid}, 8'd1);
      if (n < 259) @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check("R8 stop ends page", {7'd0, valid}, 8'd0);

    // R10: freeze with start and stop ignored
    begin_burst(3'd3, 1'b0, 8'h10);
    cke = 1'b0; start = 1'b1; stop = 1'b1; start_col = 8'h99;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 frozen column", col, 8'h10);
      check("R10 frozen valid", {7'd0, valid}, 8'd1);
    end
    idle();
    @(negedge clk);
    check("R10 resume column", col, 8'h11);

    // R9: start overrides an ongoing burst and a simultaneous stop
    @(negedge clk);
    check("R9 pre-override column", col, 8'h12);
    start = 1'b1; stop = 1'b1; start_col = 8'h40; len_code = 3'd2; ilv = 1'b1;
    @(negedge clk);
    idle();
    check("R9 new burst column", col, 8'h40);
    check("R9 new burst valid", {7'd0, valid}, 8'd1);
    @(negedge clk); check("R9 beat1", col, 8'h41);
    @(negedge clk); check("R9 beat2", col, 8'h42);
    @(negedge clk); check("R9 beat3", col, 8'h43);
    check("R9 last on beat3", {7'd0, last}, 8'd1);
    @(negedge clk);
    check("R6 ended after override burst", {7'd0, valid}, 8'd0);

    // R8: stop on a fixed burst at beat 0
    begin_burst(3'd3, 1'b0, 8'h30);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check("R8 stop fixed valid", {7'd0, valid}, 8'd0);
    check("R8 stop fixed last", {7'd0, last}, 8'd0);

    // R10: stop while cke low is ignored
    begin_burst(3'd3, 1'b0, 8'h50);
    cke = 1'b0; stop = 1'b1;
    @(negedge clk);
    idle();
    check("R10 stop ignored", {7'd0, valid}, 8'd1);
    @(negedge clk);
    check("R10 continues after freeze", col, 8'h51);

    finish_run();
  end
endmodule